// File: doc/BRIEF.md
# Guarded 36-bit Accumulator

This block holds the running sum of a fixed-point multiply-accumulate datapath. The sum is 36 bits wide: a 32-bit working word plus four guard bits above it. The guard bits let intermediate sums grow past the 32-bit range without wrapping. Each cycle at most one operation is issued. An operation can add a 16-bit upper-half value or a 32-bit register pair, shift the sum left or right by one, or load it from a 16-bit or 32-bit source with sign extension. A one-cycle `done` pulse follows every accepted operation.

Five status bits are kept beside the sum:
- an extension-overflow flag, which reports whether the guard bits currently hold more than a copy of bit 31;
- a sticky accumulator-overflow flag, which marks the first time the full 36-bit value wraps;
- a sign latch, which records the direction of that first wrap;
- a negative flag and a carry flag, which are both set by the shifts.

Downstream rounding and saturation logic reads these bits. That logic, the multiplier and all memory access lie outside this block.

Top module: `guard_accum_unit`

## Requirements
- R1: Opcode 0 (add upper) adds `{op_hi, 16'h0000}` to the accumulator. The addend is sign-extended to 36 bits, and the sum is truncated to 36 bits.
- R2: Opcode 1 (add pair) adds the 32-bit value `{op_hi, op_lo}` to the accumulator. The addend is sign-extended to 36 bits, and the sum is truncated to 36 bits.
- R3: When `op_unsigned` is high during opcode 0 or 1, the 32-bit addend is zero-extended instead of sign-extended.
- R4: After every add, shift-left or shift-right, `flag_ext_ovf` is 1 exactly when result bits 35:32 are not all equal to result bit 31.
- R5: On an add or a shift left, `flag_sticky_ovf` becomes 1 only when all three of these hold:
  - the new extension overflow is 1;
  - the sticky flag was 0;
  - result bit 35 differs from the old bit 35.
  In that same update, `sign_latch` takes the result bit 35. Apart from this case, the sticky flag keeps its value and only a load clears it. `sign_latch` changes only in this case.
- R6: Opcode 2 (shift left) shifts a 0 into bit 0. `flag_neg` takes the new bit 35 and `flag_carry` takes the old bit 35.
- R7: Opcode 3 (shift right) copies bit 35 into itself and takes `flag_carry` from the old bit 0. `flag_neg` takes the new bit 35. The sticky flag is left unchanged.
- R8: Opcode 4 (load upper) writes `op_hi` to bits 31:16 and zeroes bits 15:0. Opcode 5 (load pair) writes `{op_hi, op_lo}` to bits 31:0. Both loads fill bits 35:32 with bit 31, clear both overflow flags, and leave `flag_neg`, `flag_carry` and `sign_latch` unchanged.
- R9: While `rst_n` is low, the accumulator, all four flags, `sign_latch` and `done` are 0.
- R10: `done` is high for exactly the one cycle after an accepted operation. Opcodes 6 and 7, and cycles with `op_valid` low, change no state and produce no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_valid | input | 1 | Issues `op_code` this cycle |
| op_code | input | 3 | Operation select, encoded as in R1-R10 |
| op_hi | input | 16 | Upper operand half |
| op_lo | input | 16 | Lower operand half |
| op_unsigned | input | 1 | Zero-extend the addend on adds |
| acc | output | 36 | Accumulator value |
| flag_ext_ovf | output | 1 | Guard bits in use |
| flag_sticky_ovf | output | 1 | Full-width overflow seen since the last load |
| flag_neg | output | 1 | Sign after the last shift |
| flag_carry | output | 1 | Bit shifted out by the last shift |
| sign_latch | output | 1 | Bit 35 at the first sticky overflow |
| done | output | 1 | Operation completed |

## Verification
Two functions can fall in the same update: the extension-overflow evaluation and the first sticky overflow with its sign capture. A third, the shift flags, can land in that same update as well. The bench provokes this by loading edge values and then walking bit 35 across with shift-lefts. It does the same with a single large negative add, so both wrap directions are covered. A scoreboard model predicts all of these results from the requirements and compares them against the outputs. It also checks that a later overflow, made while the sticky flag is already set, leaves `sign_latch` alone.

// File: rtl/gau_pkg.sv
package gau_pkg;
  localparam logic [2:0] OP_ADD_HI   = 3'd0;
  localparam logic [2:0] OP_ADD_PAIR = 3'd1;
  localparam logic [2:0] OP_SHL      = 3'd2;
  localparam logic [2:0] OP_SHR      = 3'd3;
  localparam logic [2:0] OP_LOAD_HI  = 3'd4;
  localparam logic [2:0] OP_LOAD_PAIR= 3'd5;

  typedef struct packed {
    logic ext;
    logic sticky;
    logic neg;
    logic carry;
    logic latch;
  } gau_flags_t;
endpackage

// File: rtl/gau_operand.sv
module gau_operand
  import gau_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int GUARD_W = 4
) (
  input  logic [2:0]                  op,
  input  logic [HALF_W-1:0]           hi,
  input  logic [HALF_W-1:0]           lo,
  input  logic                        uns,
  output logic [2*HALF_W+GUARD_W-1:0] value
);
  localparam int WORD_W = 2 * HALF_W;

  logic [WORD_W-1:0] word;
  logic              fill;
  logic              upper_only;
  logic              is_load;

  always_comb begin
    upper_only = (op == OP_ADD_HI) || (op == OP_LOAD_HI);
    is_load    = (op == OP_LOAD_HI) || (op == OP_LOAD_PAIR);
    word       = upper_only ? {hi, {HALF_W{1'b0}}} : {hi, lo};
    fill       = word[WORD_W-1] & (is_load | ~uns);
    value      = {{GUARD_W{fill}}, word};
  end
endmodule

// File: rtl/gau_alu.sv
module gau_alu
  import gau_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int GUARD_W = 4
) (
  input  logic [2:0]                  op,
  input  logic [2*HALF_W+GUARD_W-1:0] acc_q,
  input  gau_flags_t                  flags_q,
  input  logic [2*HALF_W+GUARD_W-1:0] operand,
  output logic [2*HALF_W+GUARD_W-1:0] acc_d,
  output gau_flags_t                  flags_d,
  output logic                        legal
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int ACC_W  = WORD_W + GUARD_W;
  localparam int MSB    = ACC_W - 1;

  logic [ACC_W-1:0] res;
  logic             ev;
  logic             may_trip;

  always_comb begin
    res      = acc_q;
    flags_d  = flags_q;
    legal    = 1'b1;
    may_trip = 1'b0;
    case (op)
      OP_ADD_HI, OP_ADD_PAIR: begin
        res      = acc_q + operand;
        may_trip = 1'b1;
      end
      OP_SHL: begin
        res           = {acc_q[MSB-1:0], 1'b0};
        flags_d.neg   = res[MSB];
        flags_d.carry = acc_q[MSB];
        may_trip      = 1'b1;
      end
      OP_SHR: begin
        res           = {acc_q[MSB], acc_q[MSB:1]};
        flags_d.neg   = res[MSB];
        flags_d.carry = acc_q[0];
      end
      OP_LOAD_HI, OP_LOAD_PAIR: begin
        res = operand;
      end
      default: legal = 1'b0;
    endcase

    ev = res[MSB:WORD_W] != {GUARD_W{res[WORD_W-1]}};

    if (op == OP_LOAD_HI || op == OP_LOAD_PAIR) begin
      flags_d.ext    = 1'b0;
      flags_d.sticky = 1'b0;
    end else if (legal) begin
      flags_d.ext = ev;
    end

    if (may_trip && ev && !flags_q.sticky && (res[MSB] != acc_q[MSB])) begin
      flags_d.sticky = 1'b1;
      flags_d.latch  = res[MSB];
    end

    acc_d = res;
  end
endmodule

// File: rtl/guard_accum_unit.sv
module guard_accum_unit
  import gau_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int GUARD_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        op_valid,
  input  logic [2:0]                  op_code,
  input  logic [HALF_W-1:0]           op_hi,
  input  logic [HALF_W-1:0]           op_lo,
  input  logic                        op_unsigned,
  output logic [2*HALF_W+GUARD_W-1:0] acc,
  output logic                        flag_ext_ovf,
  output logic                        flag_sticky_ovf,
  output logic                        flag_neg,
  output logic                        flag_carry,
  output logic                        sign_latch,
  output logic                        done
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int ACC_W  = WORD_W + GUARD_W;

  logic [ACC_W-1:0] acc_q, acc_d, operand;
  gau_flags_t       flags_q, flags_d;
  logic             legal, fire, done_q;

  gau_operand #(.HALF_W(HALF_W), .GUARD_W(GUARD_W)) u_operand (
    .op(op_code), .hi(op_hi), .lo(op_lo), .uns(op_unsigned), .value(operand)
  );

  gau_alu #(.HALF_W(HALF_W), .GUARD_W(GUARD_W)) u_alu (
    .op(op_code), .acc_q(acc_q), .flags_q(flags_q), .operand(operand),
    .acc_d(acc_d), .flags_d(flags_d), .legal(legal)
  );

  always_comb fire = op_valid && legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fire;
      if (fire) begin
        acc_q   <= acc_d;
        flags_q <= flags_d;
      end
    end
  end

  assign acc             = acc_q;
  assign flag_ext_ovf    = flags_q.ext;
  assign flag_sticky_ovf = flags_q.sticky;
  assign flag_neg        = flags_q.neg;
  assign flag_carry      = flags_q.carry;
  assign sign_latch      = flags_q.latch;
  assign done            = done_q;

  p_ext_matches_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ext_ovf == (acc[ACC_W-1:WORD_W] != {GUARD_W{acc[WORD_W-1]}}));

  p_load_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_LOAD_HI || op_code == OP_LOAD_PAIR))
    |=> (!flag_ext_ovf && !flag_sticky_ovf));

  p_sticky_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_sticky_ovf && !(op_valid && (op_code == OP_LOAD_HI || op_code == OP_LOAD_PAIR)))
    |=> flag_sticky_ovf);

  p_latch_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && (op_code == OP_ADD_HI || op_code == OP_ADD_PAIR || op_code == OP_SHL))
    |=> $stable(sign_latch));

  p_shr_keeps_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SHR) |=> (acc[ACC_W-1] == $past(acc[ACC_W-1])));

  p_done_follows_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(op_valid));

  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc) && !done));
endmodule

// File: tb/test_guard_accum_unit.sv
module test_guard_accum_unit;
  localparam int PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [15:0] op_hi = '0, op_lo = '0;
  logic        op_unsigned = 1'b0;
  logic [35:0] acc;
  logic        flag_ext_ovf, flag_sticky_ovf, flag_neg, flag_carry, sign_latch, done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [35:0] acc;
    logic ext, sticky, neg, carry, latch;
    string tag;
  } exp_t;
  exp_t sb[$];

  logic [35:0] m_acc = '0;
  logic m_ext = 0, m_sticky = 0, m_neg = 0, m_carry = 0, m_latch = 0;

  always #(PERIOD/2) clk = ~clk;

  guard_accum_unit i_guard_accum_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_hi(op_hi), .op_lo(op_lo), .op_unsigned(op_unsigned), .acc(acc),
    .flag_ext_ovf(flag_ext_ovf), .flag_sticky_ovf(flag_sticky_ovf),
    .flag_neg(flag_neg), .flag_carry(flag_carry), .sign_latch(sign_latch), .done(done)
  );

  function automatic logic guard_bad(input logic [35:0] v);
    return !(v[35:32] == 4'h0 && !v[31]) && !(v[35:32] == 4'hF && v[31]);
  endfunction

  task automatic model(input logic [2:0] op, input logic [15:0] hi, lo, input logic uns);
    logic [35:0] add, r;
    logic [31:0] w;
    w = (op == 3'd0 || op == 3'd4) ? {hi, 16'h0} : {hi, lo};
    if (op <= 3'd1) begin
      add = uns ? {4'h0, w} : {{4{w[31]}}, w};
      r = m_acc + add;
    end else if (op == 3'd2) begin
      r = m_acc << 1;
      m_carry = m_acc[35]; m_neg = r[35];
    end else if (op == 3'd3) begin
      r = {m_acc[35], m_acc[35:1]};
      m_carry = m_acc[0]; m_neg = r[35];
    end else begin
      r = {{4{w[31]}}, w};
    end
    if (op >= 3'd4) begin
      m_ext = 0; m_sticky = 0;
    end else begin
      m_ext = guard_bad(r);
      if (op != 3'd3 && m_ext && !m_sticky && r[35] != m_acc[35]) begin
        m_sticky = 1; m_latch = r[35];
      end
    end
    m_acc = r;
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] hi, lo,
                       input logic uns, input string tag);
    exp_t e;
    @(negedge clk);
    op_valid = 1'b1; op_code = op; op_hi = hi; op_lo = lo; op_unsigned = uns;
    if (op <= 3'd5) begin
      model(op, hi, lo, uns);
      e.acc = m_acc; e.ext = m_ext; e.sticky = m_sticky; e.neg = m_neg;
      e.carry = m_carry; e.latch = m_latch; e.tag = tag;
      sb.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    op_valid = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic check_state(input logic [35:0] a, input logic st, input logic lt, input string tag);
    total++;
    if (acc !== a || flag_sticky_ovf !== st || sign_latch !== lt) begin
      bad++;
      $display("FAIL %s: acc=%h sticky=%b latch=%b expected acc=%h sticky=%b latch=%b",
               tag, acc, flag_sticky_ovf, sign_latch, a, st, lt);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R10 unexpected done: actual done=1 expected done=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (acc !== e.acc || flag_ext_ovf !== e.ext || flag_sticky_ovf !== e.sticky ||
            flag_neg !== e.neg || flag_carry !== e.carry || sign_latch !== e.latch) begin
          bad++;
          $display("FAIL %s: actual acc=%h e/s/n/c/l=%b%b%b%b%b expected acc=%h e/s/n/c/l=%b%b%b%b%b",
                   e.tag, acc, flag_ext_ovf, flag_sticky_ovf, flag_neg, flag_carry, sign_latch,
                   e.acc, e.ext, e.sticky, e.neg, e.carry, e.latch);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    total++;
    if (acc !== '0 || flag_ext_ovf || flag_sticky_ovf || flag_neg || flag_carry || sign_latch || done) begin
      bad++;
      $display("FAIL R9 reset: actual acc=%h done=%b expected acc=0 all flags 0", acc, done);
    end
    rst_n = 1'b1;
    idle(2);

    // R8 loads, R1/R2 adds, R4 guard use
    issue(3'd5, 16'h7FFF, 16'hFFFF, 0, "R8 load pair pos");
    issue(3'd0, 16'h0001, 16'h1234, 0, "R1 add upper R4 into guard");
    issue(3'd1, 16'hFFFF, 16'hFFFF, 0, "R2 add pair minus one");
    issue(3'd4, 16'h8000, 16'hABCD, 0, "R8 load upper neg");
    issue(3'd0, 16'h8000, 16'h0000, 0, "R1 add upper neg R4");
    // R3 unsigned qualifier
    issue(3'd5, 16'h0000, 16'h0000, 0, "R8 load zero");
    issue(3'd1, 16'hFFFF, 16'hFFFF, 1, "R3 add pair unsigned");
    issue(3'd0, 16'hFFFF, 16'h0000, 1, "R3 add upper unsigned");
    issue(3'd1, 16'hFFFF, 16'hFFFF, 0, "R2 add pair signed");
    // R5/R6 positive-to-negative wrap through shifts
    issue(3'd5, 16'h4000, 16'h0000, 0, "R8 load 0x40000000");
    for (int i = 0; i < 6; i++) issue(3'd2, 16'h0, 16'h0, 0, "R6 R5 shift left walk");
    idle(2);
    check_state(36'h0_0000_0000, 1'b1, 1'b1, "R5 sticky latch positive wrap");
    // R5 a second overflow while sticky does not move the latch
    issue(3'd1, 16'h8000, 16'h0000, 0, "R5 add after sticky");
    issue(3'd1, 16'h8000, 16'h0000, 0, "R5 add after sticky 2");
    // R8 load clears sticky, latch kept; R5 negative wrap
    issue(3'd5, 16'h8000, 16'h0000, 0, "R8 load clears sticky");
    for (int i = 0; i < 4; i++) issue(3'd2, 16'h0, 16'h0, 0, "R6 shift left neg");
    issue(3'd1, 16'h8000, 16'h0000, 0, "R5 negative wrap add");
    idle(2);
    check_state(36'h7_8000_0000, 1'b1, 1'b0, "R5 sticky latch negative wrap");
    // R7 shift right
    issue(3'd3, 16'h0, 16'h0, 0, "R7 shift right sticky kept");
    issue(3'd5, 16'h8000, 16'h0001, 0, "R8 load odd neg");
    issue(3'd3, 16'h0, 16'h0, 0, "R7 shift right neg odd");
    issue(3'd5, 16'h0000, 16'h0000, 0, "R8 load zero 2");
    issue(3'd1, 16'hFFFF, 16'hFFFF, 1, "R3 unsigned again");
    issue(3'd3, 16'h0, 16'h0, 0, "R7 shift right R4 ext clears");
    // R10 illegal codes change nothing
    issue(3'd6, 16'h1234, 16'h5678, 0, "R10 illegal 6");
    issue(3'd7, 16'hFFFF, 16'hFFFF, 0, "R10 illegal 7");
    idle(3);
    check_state(36'h0_7FFF_FFFF, 1'b0, 1'b0, "R10 illegal no effect");
    total++;
    if (sb.size() != 0 || done !== 1'b0) begin
      bad++;
      $display("FAIL R10 pending: actual left=%0d done=%b expected left=0 done=0", sb.size(), done);
    end
    finish_run();
  end
endmodule